// File: doc/BRIEF.md
# UDP Streaming Frame Transmitter

This block turns a byte stream into Ethernet frames that carry IPv4/UDP datagrams. The frames go out on a 4-bit, MII-style transmit port, one nibble per clock, and no processor is involved. Each frame starts with a preamble and a start delimiter. A header built from the configuration inputs follows, then a fixed number of payload bytes taken straight from the input stream, then zero padding up to the Ethernet minimum, and last the frame check sequence. A frame is sent once and never acknowledged or repeated.

The header is not rebuilt for every frame. The block keeps a registered copy of the configuration and a registered IPv4 header checksum. It refreshes both only between frames, and only when the configuration inputs differ from the stored copy. The UDP checksum goes out as zero, so payload bytes can pass to the wire as they arrive, with no buffering. The CRC-32 is accumulated byte by byte as the frame goes out. The source is stalled through `inReady` in every part of the frame except the payload byte slots.

Top module: `udp_stream_tx`

## Requirements
- R1: While reset is held and right after it, `txEn` is low and `inReady` is low.
- R2: Each frame opens with seven 0x55 bytes and then 0xD5. Every byte is sent as two nibbles, bits 3:0 first. `txEn` stays high from the first preamble nibble through the last check-sequence nibble.
- R3: After the delimiter come 42 header bytes, each multi-byte field most significant byte first:
  - Ethernet: destination MAC, source MAC, type 0x0800.
  - IPv4: bytes 0x45 and 0x00, total length 28+L, identification 0x0000, flags/offset 0x4000, TTL 0x40, protocol 0x11, checksum, source IP, destination IP.
  - UDP: source port, destination port, length 8+L, checksum 0x0000.
- R4: Summed in ones' complement, the ten 16-bit words of the transmitted IPv4 header give 0xFFFF.
- R5: In each frame the block accepts the payload of L bytes (the configured payload length, at least 1) in L slots and sends them in the order they were offered. `inReady` is high only in those L slots, one per byte time.
- R6: If `inValid` is low in a payload slot, that slot carries 0x00 and no input byte is consumed.
- R7: When L is less than 18, zero bytes are appended so that header, payload and padding total 60 bytes. When L is 18 or more, no padding is sent.
- R8: The last four bytes are the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, result complemented). It covers header, payload and padding, excludes the preamble and delimiter, and is sent least significant byte first.
- R9: `txEn` stays low for at least 24 clocks between frames. When data is waiting and the configuration is unchanged, the gap is exactly 24 clocks.
- R10: Configuration changes made while a frame is in progress do not alter that frame; the next frame uses the new values.
- R11: A frame starts only when `inValid` is high while the block is idle. With no data offered, no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Payload byte available |
| inData | input | 8 | Payload byte |
| inReady | output | 1 | Payload byte taken this cycle |
| cfgDstMac | input | 48 | Destination MAC address |
| cfgSrcMac | input | 48 | Source MAC address |
| cfgSrcIp | input | 32 | Source IPv4 address |
| cfgDstIp | input | 32 | Destination IPv4 address |
| cfgSrcPort | input | 16 | UDP source port |
| cfgDstPort | input | 16 | UDP destination port |
| cfgPayLen | input | LEN_W | Payload bytes per frame (L) |
| txd | output | 4 | Transmit nibble |
| txEn | output | 1 | Transmit enable |

## Verification
The first nibble appears two clocks after the idle cycle in which `inValid` is seen high. `inReady` is combinational in the cycle a payload byte is taken, and that byte's low nibble reaches `txd` one clock later. The bench samples every output on the falling edge and rebuilds each frame from the nibbles seen while `txEn` is high. It records the payload expected in each slot at the falling edge where `inReady` is high, so byte order, underrun zeros and slot counts are judged at the ports, not against a cycle number. Gap length is counted in falling edges with `txEn` low. A new configuration is expected on the first frame that starts after the change.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;
  localparam int HDR_BYTES = 42;
  localparam int HDR_BITS  = HDR_BYTES * 8;
  localparam int MIN_BODY  = 60;
  localparam int PAD_THR   = MIN_BODY - HDR_BYTES;
  localparam int PRE_BYTES = 8;

  typedef enum logic [2:0] {
    SRC_PRE, SRC_SFD, SRC_HDR, SRC_PAY, SRC_ZERO, SRC_FCS
  } srcSel_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_HDR, ST_PAY, ST_PAD, ST_FCS, ST_GAP
  } txState_e;

  typedef struct packed {
    srcSel_e    src;
    logic       nibHi;
    logic       crcInit;
    logic       crcEn;
    logic       txOn;
    logic       payTake;
    logic [1:0] fcsIdx;
  } dpCtl_t;

  typedef struct packed {
    logic [47:0] dstMac;
    logic [47:0] srcMac;
    logic [31:0] srcIp;
    logic [31:0] dstIp;
    logic [15:0] srcPort;
    logic [15:0] dstPort;
  } addrCfg_t;
endpackage

// File: rtl/udp_hdr_store.sv
module udp_hdr_store
  import udp_tx_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             allowUpd,
  input  addrCfg_t         cfgIn,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic [5:0]       hdrIdx,
  output logic [7:0]       hdrByte,
  output logic             hdrReady,
  output logic [LEN_W-1:0] snapLen
);
  addrCfg_t    snap;
  logic        busy;
  logic [15:0] ipChk;
  logic [15:0] ipTot, udpLen;
  logic        cfgDiff;
  logic [HDR_BITS-1:0] hdrVec, hdrSh;

  assign ipTot   = 16'(snapLen) + 16'd28;
  assign udpLen  = 16'(snapLen) + 16'd8;
  assign cfgDiff = (cfgIn != snap) || (cfgLen != snapLen);
  assign hdrReady = !busy && !cfgDiff;

  function automatic logic [15:0] calcChk(addrCfg_t c, logic [15:0] tot);
    logic [31:0] s;
    s = 32'h4500 + 32'(tot) + 32'h4000 + 32'h4011
      + 32'(c.srcIp[31:16]) + 32'(c.srcIp[15:0])
      + 32'(c.dstIp[31:16]) + 32'(c.dstIp[15:0]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    return ~s[15:0];
  endfunction

  // configuration copy is refreshed only between frames
  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= '0;
      snapLen <= '0;
      busy    <= 1'b1;
      ipChk   <= '0;
    end else begin
      ipChk <= calcChk(snap, ipTot);
      if (allowUpd && cfgDiff) begin
        snap    <= cfgIn;
        snapLen <= cfgLen;
        busy    <= 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  assign hdrVec = {snap.dstMac, snap.srcMac, 16'h0800, 8'h45, 8'h00, ipTot,
                   16'h0000, 16'h4000, 8'h40, 8'h11, ipChk,
                   snap.srcIp, snap.dstIp, snap.srcPort, snap.dstPort,
                   udpLen, 16'h0000};
  assign hdrSh   = hdrVec << (int'(hdrIdx) * 8);
  assign hdrByte = hdrSh[HDR_BITS-1 -: 8];
endmodule

// File: rtl/udp_tx_ctrl.sv
module udp_tx_ctrl
  import udp_tx_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int IFG_NIB = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             hdrReady,
  input  logic [LEN_W-1:0] payLen,
  output dpCtl_t           ctl,
  output logic [5:0]       hdrIdx,
  output logic             allowUpd,
  output logic             inReady
);
  localparam int CW = LEN_W + 1;

  txState_e      state, nextSt;
  logic [CW-1:0] cnt, padLen, lastCnt;
  logic          phase, lastByte;

  assign padLen = (CW'(payLen) < CW'(PAD_THR)) ? CW'(PAD_THR) - CW'(payLen) : '0;

  always_comb begin
    nextSt  = ST_GAP;
    lastCnt = CW'(3);
    unique case (state)
      ST_PRE: begin nextSt = ST_HDR; lastCnt = CW'(PRE_BYTES - 1); end
      ST_HDR: begin nextSt = ST_PAY; lastCnt = CW'(HDR_BYTES - 1); end
      ST_PAY: begin
        nextSt  = (padLen != '0) ? ST_PAD : ST_FCS;
        lastCnt = CW'(payLen) - CW'(1);
      end
      ST_PAD: begin nextSt = ST_FCS; lastCnt = padLen - CW'(1); end
      default: begin nextSt = ST_GAP; lastCnt = CW'(3); end
    endcase
  end
  assign lastByte = (cnt == lastCnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      phase <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (inValid && hdrReady && payLen != '0) begin
          state <= ST_PRE;
          cnt   <= '0;
          phase <= 1'b0;
        end
        ST_GAP: if (cnt == CW'(IFG_NIB - 2)) begin
          state <= ST_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
        default: begin
          phase <= ~phase;
          if (phase) begin
            if (lastByte) begin
              state <= nextSt;
              cnt   <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_PRE:  ctl.src = (cnt == CW'(PRE_BYTES - 1)) ? SRC_SFD : SRC_PRE;
      ST_HDR:  ctl.src = SRC_HDR;
      ST_PAY:  ctl.src = SRC_PAY;
      ST_FCS:  ctl.src = SRC_FCS;
      default: ctl.src = SRC_ZERO;
    endcase
    ctl.nibHi   = phase;
    ctl.crcInit = (state == ST_PRE);
    ctl.crcEn   = (state == ST_HDR || state == ST_PAY || state == ST_PAD) && !phase;
    ctl.txOn    = (state != ST_IDLE) && (state != ST_GAP);
    ctl.payTake = (state == ST_PAY) && !phase;
    ctl.fcsIdx  = cnt[1:0];
  end

  assign hdrIdx   = cnt[5:0];
  assign allowUpd = (state == ST_IDLE);
  assign inReady  = ctl.payTake;
endmodule

// File: rtl/udp_tx_dp.sv
module udp_tx_dp
  import udp_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpCtl_t     ctl,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic [7:0] hdrByte,
  output logic [3:0] txd,
  output logic       txEn
);
  logic [31:0] crcReg, crcAll;
  logic [7:0]  payHeld, liveByte, curByte;

  function automatic logic [31:0] crcStep(logic [31:0] c, logic [7:0] d);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  assign liveByte = inValid ? inData : 8'h00;
  assign crcAll   = ~crcReg;

  always_comb begin
    unique case (ctl.src)
      SRC_PRE: curByte = 8'h55;
      SRC_SFD: curByte = 8'hD5;
      SRC_HDR: curByte = hdrByte;
      SRC_PAY: curByte = ctl.nibHi ? payHeld : liveByte;
      SRC_FCS: curByte = crcAll[8*ctl.fcsIdx +: 8];
      default: curByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txEn    <= 1'b0;
      txd     <= 4'h0;
      crcReg  <= '1;
      payHeld <= 8'h00;
    end else begin
      txEn <= ctl.txOn;
      txd  <= ctl.nibHi ? curByte[7:4] : curByte[3:0];
      if (ctl.payTake) payHeld <= liveByte;
      if (ctl.crcInit)    crcReg <= '1;
      else if (ctl.crcEn) crcReg <= crcStep(crcReg, curByte);
    end
  end
endmodule

// File: rtl/udp_stream_tx.sv
module udp_stream_tx
  import udp_tx_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int IFG_NIB = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [7:0]       inData,
  output logic             inReady,
  input  logic [47:0]      cfgDstMac,
  input  logic [47:0]      cfgSrcMac,
  input  logic [31:0]      cfgSrcIp,
  input  logic [31:0]      cfgDstIp,
  input  logic [15:0]      cfgSrcPort,
  input  logic [15:0]      cfgDstPort,
  input  logic [LEN_W-1:0] cfgPayLen,
  output logic [3:0]       txd,
  output logic             txEn
);
  dpCtl_t           ctl;
  addrCfg_t         cfgIn;
  logic [5:0]       hdrIdx;
  logic [7:0]       hdrByte;
  logic             hdrReady, allowUpd;
  logic [LEN_W-1:0] snapLen;

  assign cfgIn = '{dstMac: cfgDstMac, srcMac: cfgSrcMac, srcIp: cfgSrcIp,
                   dstIp: cfgDstIp, srcPort: cfgSrcPort, dstPort: cfgDstPort};

  udp_hdr_store #(.LEN_W(LEN_W)) uHdr (
    .clk(clk), .rst(rst), .allowUpd(allowUpd), .cfgIn(cfgIn), .cfgLen(cfgPayLen),
    .hdrIdx(hdrIdx), .hdrByte(hdrByte), .hdrReady(hdrReady), .snapLen(snapLen)
  );

  udp_tx_ctrl #(.LEN_W(LEN_W), .IFG_NIB(IFG_NIB)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .hdrReady(hdrReady), .payLen(snapLen),
    .ctl(ctl), .hdrIdx(hdrIdx), .allowUpd(allowUpd), .inReady(inReady)
  );

  udp_tx_dp uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .inValid(inValid), .inData(inData),
    .hdrByte(hdrByte), .txd(txd), .txEn(txEn)
  );
endmodule

// File: rtl/udp_tx_checker.sv
module udp_tx_checker #(
  parameter int LEN_W   = 11,
  parameter int IFG_NIB = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             inReady,
  input logic             txEn,
  input logic [3:0]       txd,
  input logic [LEN_W-1:0] snapLen
);
  localparam int GW = $clog2(IFG_NIB + 1) + 1;
  logic [GW-1:0] lowRun;
  logic          seenFrame;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowRun    <= '0;
      seenFrame <= 1'b0;
    end else if (txEn) begin
      lowRun    <= '0;
      seenFrame <= 1'b1;
    end else if (lowRun != '1) begin
      lowRun <= lowRun + GW'(1);
    end
  end

  AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    inReady |-> txEn);                                           // R5
  AST_FIRST_NIBBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(txEn) |-> txd == 4'h5);                                 // R2
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(txEn) && seenFrame) |-> lowRun >= GW'(IFG_NIB));      // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    txEn |=> $stable(snapLen));                                   // R10
  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(txEn) |-> $past(inValid, 2));                           // R11
endmodule

bind udp_stream_tx udp_tx_checker #(.LEN_W(LEN_W), .IFG_NIB(IFG_NIB)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .txEn(txEn), .txd(txd), .snapLen(snapLen)
);

// File: tb/sim_udp_stream_tx.sv
module sim_udp_stream_tx;
  localparam int LEN_W = 11;
  localparam int IFG   = 24;
  localparam int NF    = 14;

  typedef struct {
    logic [47:0] dm, sm;
    logic [31:0] sip, dip;
    logic [15:0] sp, dp;
    int          len;
  } bcfg_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 4 time units per cycle, 250 MHz in ns

  logic inValid, inReady, txEn;
  logic [7:0] inData;
  logic [3:0] txd;
  bcfg_t cur;

  udp_stream_tx #(.LEN_W(LEN_W), .IFG_NIB(IFG)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .cfgDstMac(cur.dm), .cfgSrcMac(cur.sm), .cfgSrcIp(cur.sip), .cfgDstIp(cur.dip),
    .cfgSrcPort(cur.sp), .cfgDstPort(cur.dp), .cfgPayLen(LEN_W'(cur.len)),
    .txd(txd), .txEn(txEn)
  );

  int checks = 0, failures = 0;
  int started = 0, done = 0, zeroSlots = 0, lowRun = 0;
  bit stopSrc = 0, chg = 0, prevChg = 0;
  byte unsigned expPay[$], expF[$], got[$];
  logic [3:0] nibs[$];
  bcfg_t fcfg;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic buildExp(input bcfg_t c);
    logic [31:0] s, crc;
    logic [15:0] ck;
    int tot;
    bit fb;
    expF.delete();
    for (int i = 0; i < 7; i++) expF.push_back(8'h55);
    expF.push_back(8'hD5);
    for (int i = 5; i >= 0; i--) expF.push_back(c.dm[i*8 +: 8]);
    for (int i = 5; i >= 0; i--) expF.push_back(c.sm[i*8 +: 8]);
    tot = 28 + c.len;
    expF.push_back(8'h08); expF.push_back(8'h00);
    expF.push_back(8'h45); expF.push_back(8'h00);
    expF.push_back(8'(tot >> 8)); expF.push_back(8'(tot));
    expF.push_back(8'h00); expF.push_back(8'h00);
    expF.push_back(8'h40); expF.push_back(8'h00);
    expF.push_back(8'h40); expF.push_back(8'h11);
    s = 32'h4500 + 32'(tot) + 32'h4000 + 32'h4011 + 32'(c.sip[31:16]) + 32'(c.sip[15:0])
      + 32'(c.dip[31:16]) + 32'(c.dip[15:0]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    ck = ~s[15:0];
    expF.push_back(ck[15:8]); expF.push_back(ck[7:0]);
    for (int i = 3; i >= 0; i--) expF.push_back(c.sip[i*8 +: 8]);
    for (int i = 3; i >= 0; i--) expF.push_back(c.dip[i*8 +: 8]);
    expF.push_back(c.sp[15:8]); expF.push_back(c.sp[7:0]);
    expF.push_back(c.dp[15:8]); expF.push_back(c.dp[7:0]);
    expF.push_back(8'((8 + c.len) >> 8)); expF.push_back(8'(8 + c.len));
    expF.push_back(8'h00); expF.push_back(8'h00);
    foreach (expPay[i]) expF.push_back(expPay[i]);
    for (int i = c.len; i < 18; i++) expF.push_back(8'h00);
    crc = 32'hFFFFFFFF;
    for (int i = 8; i < expF.size(); i++)
      for (int b = 0; b < 8; b++) begin
        fb  = crc[0] ^ expF[i][b];
        crc = crc >> 1;
        if (fb) crc = crc ^ 32'hEDB88320;
      end
    crc = ~crc;
    for (int i = 0; i < 4; i++) expF.push_back(crc[i*8 +: 8]);
  endtask

  task automatic chkRange(input string req, input int lo, input int hi);
    int bad = -1;
    checks++;
    for (int i = lo; i <= hi; i++)
      if (i >= got.size() || i >= expF.size() || got[i] != expF[i]) begin
        bad = i;
        break;
      end
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s byte %0d actual %02h expected %02h", req, bad,
               (bad < got.size()) ? got[bad] : 8'hXX,
               (bad < expF.size()) ? expF[bad] : 8'hXX);
    end
  endtask

  task automatic endFrame();
    logic [31:0] s;
    int pad, n;
    check(nibs.size() % 2 == 0, "R2", "nibble count parity", nibs.size(), 0);
    got.delete();
    for (int i = 0; i + 1 < nibs.size(); i += 2) got.push_back({nibs[i+1], nibs[i]});
    buildExp(fcfg);
    pad = (fcfg.len < 18) ? 18 - fcfg.len : 0;
    n = 8 + 42 + fcfg.len + pad + 4;
    check(got.size() == n, "R7", "frame bytes", got.size(), n);
    check(expPay.size() == fcfg.len, "R5", "ready slots", expPay.size(), fcfg.len);
    chkRange("R2 preamble", 0, 7);
    chkRange("R3 header", 8, 31);
    chkRange(prevChg ? "R10 header after change" : "R3 header", 34, 49);
    chkRange((zeroSlots > 0) ? "R6 payload with underrun" : "R5 payload",
             50, 50 + fcfg.len - 1);
    if (pad > 0) chkRange("R7 pad", 50 + fcfg.len, 50 + fcfg.len + pad - 1);
    chkRange("R8 fcs", n - 4, n - 1);
    s = 0;
    if (got.size() >= 42)
      for (int i = 22; i < 42; i += 2) s = s + {16'h0, got[i], got[i+1]};
    s = 32'(s[15:0]) + 32'(s[31:16]);
    s = 32'(s[15:0]) + 32'(s[31:16]);
    check(s[15:0] == 16'hFFFF, "R4", "ip header sum", int'(s[15:0]), 32'hFFFF);
  endtask

  function automatic bcfg_t nextCfg(int k, bcfg_t p);
    bcfg_t c = p;
    if (k == 1) c.len = 17;
    else if (k == 2) c.len = 18;
    else begin
      c.dm = {16'($urandom), $urandom};
      c.sm = {16'($urandom), $urandom};
      c.sip = $urandom; c.dip = $urandom;
      c.sp = 16'($urandom); c.dp = 16'($urandom);
      c.len = (k == 6) ? 300 : 1 + int'($urandom % 64);
    end
    return c;
  endfunction

  // source: records expected payload per ready slot
  initial begin
    logic slot;
    inValid = 1'b0;
    inData  = 8'h00;
    wait (!rst);
    @(posedge clk); #1 inValid = 1'b1; inData = 8'($urandom);
    forever begin
      @(negedge clk);
      slot = inReady;
      if (slot) begin
        expPay.push_back(inValid ? inData : 8'h00);
        if (!inValid) zeroSlots++;
      end
      @(posedge clk); #1;
      if (slot || !inValid) inData = 8'($urandom);
      if (stopSrc) inValid = 1'b0;
      else if (txEn) inValid = ($urandom % 5) != 0;
      else inValid = 1'b1;
    end
  end

  // monitor
  initial begin
    bit inFrame = 0;
    wait (!rst);
    forever begin
      @(negedge clk);
      if (txEn) begin
        if (!inFrame) begin
          inFrame = 1;
          nibs.delete();
          expPay.delete();
          zeroSlots = 0;
          fcfg = cur;
          prevChg = chg;
          if (started > 0) begin
            check(lowRun >= IFG, "R9", "gap minimum", lowRun, IFG);
            if (!prevChg) check(lowRun == IFG, "R9", "gap back to back", lowRun, IFG);
          end
          chg = 0;
          started++;
        end
        nibs.push_back(txd);
      end else if (inFrame) begin
        inFrame = 0;
        endFrame();
        done++;
        lowRun = 1;
      end else begin
        lowRun++;
      end
    end
  end

  // driver and directed sequence
  initial begin
    void'($urandom(32'd4242));
    cur = '{dm: 48'h02_11_22_33_44_55, sm: 48'h02_AA_BB_CC_DD_EE,
            sip: 32'hC0A8_0A02, dip: 32'hC0A8_0A01, sp: 16'd5000, dp: 16'd6000, len: 1};
    repeat (4) @(negedge clk);
    check(txEn == 1'b0, "R1", "txEn in reset", int'(txEn), 0);
    check(inReady == 1'b0, "R1", "inReady in reset", int'(inReady), 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(txEn == 1'b0 && inReady == 1'b0, "R1", "outputs after reset",
          int'(txEn) + int'(inReady), 0);
    for (int k = 1; k < NF; k++) begin
      wait (started == k);
      repeat (40) @(negedge clk);
      if (k <= 2 || (k % 2) == 0) begin
        cur = nextCfg(k, cur);
        chg = 1;
      end
    end
    wait (started == NF);
    repeat (40) @(negedge clk);
    stopSrc = 1;
    wait (done == NF);
    repeat (300) @(negedge clk);
    check(started == NF, "R11", "frames without data", started, NF);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual %0d frames expected %0d", done, NF);
    summary();
    $finish;
  end
endmodule